// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Model

This block is a cycle-accurate model of a burst-capable synchronous static RAM, sized by parameters so that simulation stays small. On each rising clock edge the block decodes two competing address strobes, an advance input, three chip selects and a set of write enables. From these it picks one action: deselect, start a burst read, start a burst write, step to the next burst address, or hold the current address. Writes can cover the whole word or only chosen byte lanes.

Read data comes from a memory whose read port is registered. In pipelined mode the data then passes through one further output register. In flow-through mode that register is bypassed. A static pin selects the mode, and a second static pin selects interleaved or linear burst ordering. Output drive is reported on a separate enable port. An asynchronous output-enable input gates it, and a write edge turns it off. A sleep input freezes all internal state while the memory keeps its contents.

Top module: `burst_sram`

## Requirements
- R1: While reset is high and after it is released, `dout_en` is 0 and no burst is active, so an advance with both strobes high reads nothing.
- R2: `pstb_n`=0 with `cs_main_n`=0, `cs_hi`=1 and `cs_lo_n`=0 starts a read at `addr`. This holds whatever `cstb_n`, `gw_n`, `bw_n` and `lane_wr_n` are, and no write takes place on that edge.
- R3: When `cs_main_n`=1, `pstb_n` is ignored. `cstb_n`=0 with `cs_main_n`=1 is a deselect, and after it a later advance does not restart a burst.
- R4: `cstb_n`=0 with `pstb_n`=1 and the chip selects active starts a burst. The write enables sampled on that edge decide between read and write, and `gw_n`=0 writes all lanes.
- R5: When `gw_n`=1 and `bw_n`=0, only the lanes whose `lane_wr_n` bit is 0 are written (bit l controls `din[8l+7:8l]`). When no lane is enabled, the cycle is a read.
- R6: With both strobes high, `adv_n`=0 moves to the next burst address and `adv_n`=1 stays on the current one. The two low address bits are `base ^ count` when `burst_lin`=0 and `base + count` (mod 4) when `burst_lin`=1, where count starts at 0 and increases by one per advance.
- R7: With `flow_thru`=0, data for an address taken on edge k appears on `dout` with `dout_en`=1 after edge k+1. With `flow_thru`=1 it appears after edge k.
- R8: On an edge that performs a write, the output drive is turned off, so `dout_en` is 0 after that edge even when `oe_n`=0.
- R9: `oe_n`=1 forces `dout_en` to 0 at once, with no clock edge. `oe_n`=0 restores the drive.
- R10: In pipelined mode, a deselect edge that follows a read leaves `dout_en` high for one more cycle. It drops after the next edge.
- R11: While `sleep`=1, `dout_en` is 0 and no state changes. When sleep ends, the output and the burst position continue as before, and writes attempted during sleep are lost.
- R12: Hold and advance cycles proceed with the chip selects inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| flow_thru | input | 1 | Static: 1 selects flow-through output timing |
| burst_lin | input | 1 | Static: 1 selects linear burst order, 0 selects interleaved |
| sleep | input | 1 | 1 freezes all state and turns off drive |
| cs_main_n | input | 1 | Master chip select, active low; gates the processor strobe |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write all lanes, active low |
| bw_n | input | 1 | Lane-write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| addr | input | AW | Word address |
| din | input | DW | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | DW | Read data |
| dout_en | output | 1 | High while the read data is driven |

## Verification
A read taken on edge k is due after edge k+1 in pipelined mode and after edge k in flow-through mode. A deselect removes the drive one edge later than a write does. The output-enable and sleep gating act with no edge at all. Each task drives its inputs just after a rising edge and samples the outputs at that same point after the next edge, so every check lands in the exact cycle computed from the register count. The only exceptions are the output-enable and sleep checks, which sample a short delay after the input change and before any edge. To tell a missed write from a late one, a reread through a fresh processor-strobe read confirms whether an edge wrote or left the memory untouched.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_BEGIN = 2'd1,
    OP_CONT  = 2'd2,
    OP_SUSP  = 2'd3
  } op_e;
endpackage

// File: rtl/sram_cycle_decode.sv
module sram_cycle_decode
  import sram_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             pstb_n,
  input  logic             cstb_n,
  input  logic             adv_n,
  input  logic             cs_main_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             active,
  output op_e              op,
  output logic [LANES-1:0] lane_we
);
  logic             sel_ok;
  logic [LANES-1:0] lanes_req;

  assign sel_ok = cs_hi & ~cs_lo_n;

  always_comb begin
    if (!gw_n)      lanes_req = '1;
    else if (!bw_n) lanes_req = ~lane_wr_n;
    else            lanes_req = '0;
  end

  always_comb begin
    op      = OP_IDLE;
    lane_we = '0;
    if (!cstb_n && cs_main_n) begin
      op = OP_IDLE;                              // controller strobe while unselected
    end else if (!pstb_n && !cs_main_n) begin
      op = sel_ok ? OP_BEGIN : OP_IDLE;          // always a read, enables ignored
    end else if (!cstb_n) begin
      if (sel_ok) begin
        op      = OP_BEGIN;
        lane_we = lanes_req;
      end
    end else if (active) begin
      op      = adv_n ? OP_SUSP : OP_CONT;
      lane_we = lanes_req;
    end
  end
endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
  import sram_pkg::*;
#(
  parameter int AW = 6,
  parameter int BB = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  op_e           op,
  input  logic          linear,
  input  logic [AW-1:0] ext_addr,
  output logic [AW-1:0] acc_addr,
  output logic          active
);
  logic [AW-1:0] base;
  logic [BB-1:0] cnt;
  logic [BB-1:0] cnt_use;
  logic [BB-1:0] low;

  assign cnt_use = (op == OP_CONT) ? cnt + 1'b1 : cnt;
  assign low     = linear ? (base[BB-1:0] + cnt_use) : (base[BB-1:0] ^ cnt_use);

  always_comb begin
    if (op == OP_BEGIN) acc_addr = ext_addr;
    else                acc_addr = {base[AW-1:BB], low};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base   <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (en) begin
      case (op)
        OP_BEGIN: begin
          base   <= ext_addr;
          cnt    <= '0;
          active <= 1'b1;
        end
        OP_CONT:  cnt    <= cnt_use;
        OP_IDLE:  active <= 1'b0;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 64,
  localparam int AW    = $clog2(DEPTH),
  localparam int DW    = LANES * BYTE_W
) (
  input  logic             clk,
  input  logic             en,
  input  logic [LANES-1:0] we,
  input  logic             re,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    rd_data
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BYTE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (en && we[l]) mem[addr] <= din[l*BYTE_W +: BYTE_W];
      if (en && re)    rd_data[l*BYTE_W +: BYTE_W] <= mem[addr];
    end
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import sram_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int BYTE_W     = 8,
  parameter int DEPTH      = 64,
  parameter int BURST_BITS = 2,
  localparam int AW        = $clog2(DEPTH),
  localparam int DW        = LANES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flow_thru,
  input  logic             burst_lin,
  input  logic             sleep,
  input  logic             cs_main_n,
  input  logic             cs_hi,
  input  logic             cs_lo_n,
  input  logic             pstb_n,
  input  logic             cstb_n,
  input  logic             adv_n,
  input  logic             gw_n,
  input  logic             bw_n,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    din,
  input  logic             oe_n,
  output logic [DW-1:0]    dout,
  output logic             dout_en
);
  op_e              op_code;
  logic [LANES-1:0] lane_we;
  logic             active;
  logic [AW-1:0]    acc_addr;
  logic [DW-1:0]    rd_data;
  logic             wr_op;
  logic             rd_op;
  logic             run;
  logic             valid_rd;
  logic             drive_p;
  logic [DW-1:0]    out_q;

  assign run   = ~sleep;
  assign wr_op = |lane_we;
  assign rd_op = (op_code != OP_IDLE) && !wr_op;

  sram_cycle_decode #(.LANES(LANES)) dec_i (
    .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
    .cs_main_n(cs_main_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .gw_n(gw_n), .bw_n(bw_n), .lane_wr_n(lane_wr_n),
    .active(active), .op(op_code), .lane_we(lane_we)
  );

  sram_burst_addr #(.AW(AW), .BB(BURST_BITS)) bur_i (
    .clk(clk), .rst(rst), .en(run), .op(op_code), .linear(burst_lin),
    .ext_addr(addr), .acc_addr(acc_addr), .active(active)
  );

  sram_byte_array #(.LANES(LANES), .BYTE_W(BYTE_W), .DEPTH(DEPTH)) arr_i (
    .clk(clk), .en(run), .we(lane_we), .re(rd_op),
    .addr(acc_addr), .din(din), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_rd <= 1'b0;
      drive_p  <= 1'b0;
      out_q    <= '0;
    end else if (run) begin
      valid_rd <= rd_op;
      drive_p  <= valid_rd & ~wr_op;
      if (valid_rd) out_q <= rd_data;
    end
  end

  assign dout    = flow_thru ? rd_data : out_q;
  assign dout_en = (flow_thru ? valid_rd : drive_p) & ~oe_n & ~sleep;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk
  import sram_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic sleep,
  input logic oe_n,
  input logic flow_thru,
  input logic dout_en,
  input logic wr_op,
  input logic valid_rd,
  input logic drive_p,
  input op_e  op_code
);
  // R8
  wr_drive_off_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_op && !sleep) |=> !dout_en);

  // R10
  dual_dsel_chk: assert property (@(posedge clk) disable iff (rst)
    (!flow_thru && !sleep && valid_rd && op_code == OP_IDLE) |=> drive_p);

  // R7
  pipe_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (!flow_thru && !sleep && !valid_rd) |=> !drive_p);

  // R11
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |=> ($stable(valid_rd) && $stable(drive_p)));

  // R11
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dout_en);

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> !dout_en);
endmodule

bind burst_sram burst_sram_chk chk_i (
  .clk(clk), .rst(rst), .sleep(sleep), .oe_n(oe_n), .flow_thru(flow_thru),
  .dout_en(dout_en), .wr_op(wr_op), .valid_rd(valid_rd), .drive_p(drive_p),
  .op_code(op_code)
);

// File: tb/burst_sram_tb_top.sv
module burst_sram_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flow_thru = 1'b0, burst_lin = 1'b0, sleep = 1'b0;
  logic        cs_main_n, cs_hi, cs_lo_n, pstb_n, cstb_n, adv_n, gw_n, bw_n, oe_n;
  logic [3:0]  lane_wr_n;
  logic [5:0]  addr = '0;
  logic [31:0] din;
  logic [31:0] dout;
  logic        dout_en;
  int          ntests = 0, nfail = 0;

  burst_sram dut_i (
    .clk(clk), .rst(rst), .flow_thru(flow_thru), .burst_lin(burst_lin), .sleep(sleep),
    .cs_main_n(cs_main_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .pstb_n(pstb_n),
    .cstb_n(cstb_n), .adv_n(adv_n), .gw_n(gw_n), .bw_n(bw_n), .lane_wr_n(lane_wr_n),
    .addr(addr), .din(din), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] pat(input int a);
    return {8'(a + 8'h10), 8'(a + 8'h20), 8'(a + 8'h30), 8'(a + 8'h40)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic set_idle();
    pstb_n = 1; cstb_n = 1; adv_n = 1; gw_n = 1; bw_n = 1; lane_wr_n = '1;
    cs_main_n = 0; cs_hi = 1; cs_lo_n = 0; oe_n = 0; sleep = 0; din = '0;
  endtask

  task automatic deselect_in();
    set_idle();
    cstb_n = 0; cs_main_n = 1;
  endtask

  task automatic write_word(input int a, input logic [31:0] d);
    set_idle(); cstb_n = 0; gw_n = 0; addr = 6'(a); din = d;
    tick();
    deselect_in();
    tick();
  endtask

  task automatic read_pipe(input int a, input logic [31:0] exp, input string tag);
    set_idle(); pstb_n = 0; addr = 6'(a);
    tick();
    deselect_in();
    tick();
    chk(tag, {31'b0, dout_en}, 32'd1);
    chk(tag, dout, exp);
    tick();
    chk("R10", {31'b0, dout_en}, 32'd0);
  endtask

  task automatic t_reset();
    set_idle();
    tick();
    chk("R1", {31'b0, dout_en}, 32'd0);
    rst = 0;
    adv_n = 0;
    tick(); tick();
    chk("R1", {31'b0, dout_en}, 32'd0);
    deselect_in(); tick();
  endtask

  task automatic t_fill();
    for (int a = 0; a < 32; a++) write_word(a, pat(a));
    read_pipe(12, pat(12), "R4");
  endtask

  task automatic t_pstb_read();
    set_idle(); pstb_n = 0; cstb_n = 0; gw_n = 0; bw_n = 0; lane_wr_n = '0;
    din = 32'hDEADBEEF; addr = 6'd5;
    tick();
    chk("R7", {31'b0, dout_en}, 32'd0);
    deselect_in();
    tick();
    chk("R2", {31'b0, dout_en}, 32'd1);
    chk("R2", dout, pat(5));
    tick();
    chk("R10", {31'b0, dout_en}, 32'd0);
    read_pipe(5, pat(5), "R2");
  endtask

  task automatic t_flow();
    flow_thru = 1;
    set_idle(); pstb_n = 0; addr = 6'd9;
    tick();
    chk("R7", {31'b0, dout_en}, 32'd1);
    chk("R7", dout, pat(9));
    deselect_in();
    tick();
    chk("R7", {31'b0, dout_en}, 32'd0);
    flow_thru = 0;
    tick();
  endtask

  task automatic t_burst(input logic lin, input string tag);
    logic [31:0] e [5];
    for (int j = 0; j < 4; j++) begin
      int lo;
      lo = lin ? ((1 + j) & 3) : (1 ^ j);
      e[j] = pat(4 | lo);
    end
    e[4] = e[3];
    burst_lin = lin;
    set_idle(); pstb_n = 0; addr = 6'd5;
    tick();
    for (int i = 0; i < 3; i++) begin
      set_idle(); cs_main_n = 1; cs_hi = 0; cs_lo_n = 1; adv_n = 0;
      tick();
      chk(i == 0 ? "R12" : tag, dout, e[i]);
    end
    set_idle(); pstb_n = 0; cs_main_n = 1; addr = 6'd20; adv_n = 1;
    tick();
    chk(tag, dout, e[3]);
    deselect_in();
    tick();
    chk("R3", dout, e[4]);
    chk("R10", {31'b0, dout_en}, 32'd1);
    tick();
    chk("R3", {31'b0, dout_en}, 32'd0);
    set_idle(); adv_n = 0;
    tick(); tick();
    chk("R3", {31'b0, dout_en}, 32'd0);
    deselect_in(); tick();
    burst_lin = 0;
  endtask

  task automatic t_burst_write();
    set_idle(); cstb_n = 0; gw_n = 0; addr = 6'd40; din = 32'h40404040;
    tick();
    set_idle(); adv_n = 0; gw_n = 0; din = 32'h41414141;
    tick();
    deselect_in(); tick();
    read_pipe(40, 32'h40404040, "R4");
    read_pipe(41, 32'h41414141, "R6");
  endtask

  task automatic t_bytes();
    set_idle(); cstb_n = 0; bw_n = 0; lane_wr_n = 4'b1010; addr = 6'd30; din = 32'h11223344;
    tick();
    set_idle(); cstb_n = 0; bw_n = 1; lane_wr_n = 4'b0000; addr = 6'd31; din = 32'hFFFFFFFF;
    tick();
    deselect_in();
    tick();
    chk("R5", {31'b0, dout_en}, 32'd1);
    chk("R5", dout, pat(31));
    tick();
    read_pipe(31, pat(31), "R5");
    read_pipe(30, {pat(30)[31:24], 8'h22, pat(30)[15:8], 8'h44}, "R5");
  endtask

  task automatic t_write_off();
    set_idle(); pstb_n = 0; addr = 6'd8;
    tick();
    set_idle();
    tick();
    chk("R8", {31'b0, dout_en}, 32'd1);
    chk("R8", dout, pat(8));
    set_idle(); gw_n = 0; din = 32'hCAFE0008;
    tick();
    chk("R8", {31'b0, dout_en}, 32'd0);
    deselect_in(); tick(); tick();
    read_pipe(8, 32'hCAFE0008, "R6");
  endtask

  task automatic t_oe();
    set_idle(); pstb_n = 0; addr = 6'd3;
    tick();
    set_idle();
    tick();
    chk("R9", {31'b0, dout_en}, 32'd1);
    oe_n = 1; #1;
    chk("R9", {31'b0, dout_en}, 32'd0);
    oe_n = 0; #1;
    chk("R9", {31'b0, dout_en}, 32'd1);
    chk("R9", dout, pat(3));
    deselect_in(); tick(); tick();
  endtask

  task automatic t_sleep();
    set_idle(); pstb_n = 0; addr = 6'd10;
    tick();
    set_idle();
    tick();
    chk("R11", dout, pat(10));
    sleep = 1; cstb_n = 0; gw_n = 0; din = 32'hBAD0BAD0; addr = 6'd10; #1;
    chk("R11", {31'b0, dout_en}, 32'd0);
    tick(); tick();
    chk("R11", {31'b0, dout_en}, 32'd0);
    set_idle(); adv_n = 0; #1;
    chk("R11", {31'b0, dout_en}, 32'd1);
    chk("R11", dout, pat(10));
    tick();
    chk("R11", dout, pat(10));
    set_idle();
    tick();
    chk("R11", dout, pat(11));
    deselect_in(); tick(); tick();
    read_pipe(10, pat(10), "R11");
  endtask

  initial begin
    #4_000_000;
    ntests++; nfail++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_pstb_read();
    t_flow();
    t_burst(1'b0, "R6");
    t_burst(1'b1, "R6");
    t_burst_write();
    t_bytes();
    t_write_off();
    t_oe();
    t_sleep();
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule